// File: doc/BRIEF.md
# Address-space-tagged translation cache

This block is a small fully associative cache of page translations. It turns a virtual page number into a physical frame number for many address spaces at the same time. Each stored translation carries the identifier of the address space it belongs to. A lookup matches only when the page number and the identifier both agree. Because of this, translations from a process that has been switched out can stay in the cache and be used again when that process runs next.

A lookup is answered in the same cycle it is presented. On a miss the block only reports the miss. Walking the page tables and refilling the cache are left to the surrounding logic, which uses the fill port. The identifier of the running address space is held in a register that is rewritten on every context switch. The block also holds a page-table base register. A mode input decides whether a write to that register empties the whole cache or leaves the tagged entries in place. A separate flush input always empties the cache.

Top module: `tlb_asid_cache`

## Requirements
- R1: After synchronous reset every entry is invalid, `cur_asid` reads 0 and `ptb_q` reads 0.
- R2: `lkp_hit` is 1 in the same cycle as `lkp_vpn` only if some valid entry holds that page number and its identifier equals `cur_asid`. `lkp_pfn` then gives that entry's frame.
- R3: A write on `asid_we` loads `asid_wdata` into `cur_asid` at the clock edge. Lookups from the next cycle on use the new identifier.
- R4: Valid entries with the same page number but different identifiers can exist together. Each lookup returns only the frame stored under the current identifier.
- R5: Entries with different page numbers under different identifiers can map to the same frame, and each still hits under its own identifier only.
- R6: A cycle with `flush_req` high clears every valid bit at the clock edge.
- R7: `ptb_we` loads `ptb_wdata` into `ptb_q`. When `flush_mode` is 1 the same edge clears every valid bit. When `flush_mode` is 0 every entry is kept.
- R8: A fill whose page number and current identifier already match an entry overwrites that entry. Duplicates never form, and at most one entry matches any lookup.
- R9: A fill with no matching entry goes to the lowest-numbered invalid entry. When all entries are valid, victims are taken in round-robin order, starting at entry 0 after reset.
- R10: When a flush from `flush_req`, or from a page-table base write with `flush_mode` 1, comes in the same cycle as a fill, the flush wins and the fill is dropped.
- R11: On a miss `lkp_pfn` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lkp_vpn | input | VPN_W | Page number to translate |
| lkp_hit | output | 1 | Lookup matched a valid entry under the current identifier |
| lkp_pfn | output | PFN_W | Translated frame number, 0 on a miss |
| fill_en | input | 1 | Write a translation under the current identifier |
| fill_vpn | input | VPN_W | Page number of the translation being filled |
| fill_pfn | input | PFN_W | Frame number of the translation being filled |
| asid_we | input | 1 | Load a new current identifier |
| asid_wdata | input | ASID_W | New current identifier |
| cur_asid | output | ASID_W | Current address space identifier |
| ptb_we | input | 1 | Write the page-table base register |
| ptb_wdata | input | PTB_W | New page-table base value |
| ptb_q | output | PTB_W | Page-table base register contents |
| flush_mode | input | 1 | 1: a base register write empties the cache; 0: entries are kept |
| flush_req | input | 1 | Empty the cache at this edge |

## Verification
The bench uses the default parameters: 16 entries, 20-bit page and frame numbers, 8-bit identifiers and a 32-bit base register. With only 16 entries, a few dozen fills are enough to fill every slot. They also push the round-robin victim pointer past its first positions, so both the free-slot path and the replacement path get exercised. The 8-bit identifier lets the bench place the same page number under several address spaces and check that each lookup sees only its own frame.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Where a fill lands in the entry array
    typedef enum logic [1:0] {
        SLOT_HIT    = 2'd0,   // overwrite the entry already holding the key
        SLOT_FREE   = 2'd1,   // lowest-numbered invalid entry
        SLOT_VICTIM = 2'd2    // round-robin replacement
    } slot_src_e;

    // Effect of a page-table base write on the stored entries
    typedef enum logic {
        PTB_KEEP  = 1'b0,
        PTB_FLUSH = 1'b1
    } ptb_mode_e;

    // Default geometry
    localparam int unsigned DEF_ENTRIES = 16;
    localparam int unsigned DEF_VPN_W   = 20;
    localparam int unsigned DEF_PFN_W   = 20;
    localparam int unsigned DEF_ASID_W  = 8;
    localparam int unsigned DEF_PTB_W   = 32;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tlb_ctx_regs.sv
module tlb_ctx_regs
    import tlb_pkg::*;
#(
    parameter int unsigned ASID_W = DEF_ASID_W,
    parameter int unsigned PTB_W  = DEF_PTB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              asid_we,
    input  logic [ASID_W-1:0] asid_wdata,
    input  logic              ptb_we,
    input  logic [PTB_W-1:0]  ptb_wdata,
    input  logic              flush_mode,
    input  logic              flush_req,
    output logic [ASID_W-1:0] cur_asid,
    output logic [PTB_W-1:0]  ptb_q,
    output logic              flush_all
);

    ptb_mode_e mode;

    always_comb begin
        mode      = ptb_mode_e'(flush_mode);
        flush_all = flush_req | (ptb_we & (mode == PTB_FLUSH));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_asid <= '0;
            ptb_q    <= '0;
        end else begin
            if (asid_we) cur_asid <= asid_wdata;
            if (ptb_we)  ptb_q    <= ptb_wdata;
        end
    end

endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = DEF_ENTRIES,
    parameter int unsigned VPN_W   = DEF_VPN_W,
    parameter int unsigned ASID_W  = DEF_ASID_W
) (
    input  logic [ENTRIES-1:0] ent_valid,
    input  logic [VPN_W-1:0]   ent_vpn  [ENTRIES],
    input  logic [ASID_W-1:0]  ent_asid [ENTRIES],
    input  logic [VPN_W-1:0]   key_vpn,
    input  logic [ASID_W-1:0]  key_asid,
    output logic [ENTRIES-1:0] hit_vec
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = ent_valid[g]
                          && (ent_vpn[g]  == key_vpn)
                          && (ent_asid[g] == key_asid);
    end

endmodule

// File: rtl/tlb_alloc.sv
module tlb_alloc
    import tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = DEF_ENTRIES,
    localparam int unsigned IDX_W  = idx_width(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fill_go,
    input  logic [ENTRIES-1:0] match_vec,
    input  logic [ENTRIES-1:0] ent_valid,
    output logic               wr_en,
    output logic [IDX_W-1:0]   wr_idx,
    output slot_src_e          wr_src
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] rr_ptr;
    logic [IDX_W-1:0] match_idx;
    logic [IDX_W-1:0] free_idx;
    logic             any_match;
    logic             any_free;

    // Lowest-index encoders for the match and free vectors
    always_comb begin
        match_idx = '0;
        free_idx  = '0;
        any_match = 1'b0;
        any_free  = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                match_idx = IDX_W'(i);
                any_match = 1'b1;
            end
            if (!ent_valid[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end

    always_comb begin
        if (any_match) begin
            wr_src = SLOT_HIT;
            wr_idx = match_idx;
        end else if (any_free) begin
            wr_src = SLOT_FREE;
            wr_idx = free_idx;
        end else begin
            wr_src = SLOT_VICTIM;
            wr_idx = rr_ptr;
        end
        wr_en = fill_go;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_ptr <= '0;
        end else if (fill_go && wr_src == SLOT_VICTIM) begin
            rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
        end
    end

endmodule

// File: rtl/tlb_array.sv
module tlb_array
    import tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = DEF_ENTRIES,
    parameter int unsigned VPN_W   = DEF_VPN_W,
    parameter int unsigned PFN_W   = DEF_PFN_W,
    parameter int unsigned ASID_W  = DEF_ASID_W,
    localparam int unsigned IDX_W  = idx_width(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush_all,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [PFN_W-1:0]   wr_pfn,
    input  logic [ASID_W-1:0]  wr_asid,
    output logic [ENTRIES-1:0] ent_valid,
    output logic [VPN_W-1:0]   ent_vpn  [ENTRIES],
    output logic [PFN_W-1:0]   ent_pfn  [ENTRIES],
    output logic [ASID_W-1:0]  ent_asid [ENTRIES]
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst || flush_all) begin
                ent_valid[g] <= 1'b0;
            end else if (sel) begin
                ent_valid[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_vpn[g]  <= '0;
                ent_pfn[g]  <= '0;
                ent_asid[g] <= '0;
            end else if (sel && !flush_all) begin
                ent_vpn[g]  <= wr_vpn;
                ent_pfn[g]  <= wr_pfn;
                ent_asid[g] <= wr_asid;
            end
        end
    end

endmodule

// File: rtl/tlb_asid_cache.sv
module tlb_asid_cache
    import tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = DEF_ENTRIES,
    parameter int unsigned VPN_W   = DEF_VPN_W,
    parameter int unsigned PFN_W   = DEF_PFN_W,
    parameter int unsigned ASID_W  = DEF_ASID_W,
    parameter int unsigned PTB_W   = DEF_PTB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [VPN_W-1:0]  lkp_vpn,
    output logic              lkp_hit,
    output logic [PFN_W-1:0]  lkp_pfn,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic              asid_we,
    input  logic [ASID_W-1:0] asid_wdata,
    output logic [ASID_W-1:0] cur_asid,
    input  logic              ptb_we,
    input  logic [PTB_W-1:0]  ptb_wdata,
    output logic [PTB_W-1:0]  ptb_q,
    input  logic              flush_mode,
    input  logic              flush_req
);

    localparam int unsigned IDX_W = idx_width(ENTRIES);

    logic               flush_all;
    logic [ENTRIES-1:0] valid_vec;
    logic [VPN_W-1:0]   ent_vpn  [ENTRIES];
    logic [PFN_W-1:0]   ent_pfn  [ENTRIES];
    logic [ASID_W-1:0]  ent_asid [ENTRIES];
    logic [ENTRIES-1:0] lkp_hit_vec;
    logic [ENTRIES-1:0] fill_hit_vec;
    logic               wr_en;
    logic [IDX_W-1:0]   wr_idx;
    slot_src_e          wr_src;

    tlb_ctx_regs #(.ASID_W(ASID_W), .PTB_W(PTB_W)) u_ctx (
        .clk        (clk),
        .rst        (rst),
        .asid_we    (asid_we),
        .asid_wdata (asid_wdata),
        .ptb_we     (ptb_we),
        .ptb_wdata  (ptb_wdata),
        .flush_mode (flush_mode),
        .flush_req  (flush_req),
        .cur_asid   (cur_asid),
        .ptb_q      (ptb_q),
        .flush_all  (flush_all)
    );

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lkp_cmp (
        .ent_valid (valid_vec),
        .ent_vpn   (ent_vpn),
        .ent_asid  (ent_asid),
        .key_vpn   (lkp_vpn),
        .key_asid  (cur_asid),
        .hit_vec   (lkp_hit_vec)
    );

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fill_cmp (
        .ent_valid (valid_vec),
        .ent_vpn   (ent_vpn),
        .ent_asid  (ent_asid),
        .key_vpn   (fill_vpn),
        .key_asid  (cur_asid),
        .hit_vec   (fill_hit_vec)
    );

    tlb_alloc #(.ENTRIES(ENTRIES)) u_alloc (
        .clk       (clk),
        .rst       (rst),
        .fill_go   (fill_en & ~flush_all),
        .match_vec (fill_hit_vec),
        .ent_valid (valid_vec),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_src    (wr_src)
    );

    tlb_array #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PFN_W   (PFN_W),
        .ASID_W  (ASID_W)
    ) u_array (
        .clk       (clk),
        .rst       (rst),
        .flush_all (flush_all),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_vpn    (fill_vpn),
        .wr_pfn    (fill_pfn),
        .wr_asid   (cur_asid),
        .ent_valid (valid_vec),
        .ent_vpn   (ent_vpn),
        .ent_pfn   (ent_pfn),
        .ent_asid  (ent_asid)
    );

    // AND-OR read mux: at most one entry matches a key
    always_comb begin
        lkp_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            lkp_pfn |= ent_pfn[i] & {PFN_W{lkp_hit_vec[i]}};
        end
        lkp_hit = |lkp_hit_vec;
    end

endmodule

// File: rtl/tlb_asid_checker.sv
module tlb_asid_checker #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned PFN_W   = 20,
    parameter int unsigned ASID_W  = 8,
    parameter int unsigned PTB_W   = 32
) (
    input logic               clk,
    input logic               rst,
    input logic [ENTRIES-1:0] valid_vec,
    input logic [ENTRIES-1:0] lkp_hit_vec,
    input logic               lkp_hit,
    input logic [PFN_W-1:0]   lkp_pfn,
    input logic               asid_we,
    input logic [ASID_W-1:0]  asid_wdata,
    input logic [ASID_W-1:0]  cur_asid,
    input logic               ptb_we,
    input logic [PTB_W-1:0]   ptb_q,
    input logic               flush_mode,
    input logic               flush_req,
    input logic               fill_en
);

    // R1: state right after reset is released
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (valid_vec == '0 && cur_asid == '0 && ptb_q == '0));

    // R3: identifier register loads the written value
    p_asid_load_r3: assert property (@(posedge clk) disable iff (rst)
        asid_we |=> (cur_asid == $past(asid_wdata)));

    // R6: explicit flush empties the array
    p_flush_empty_r6: assert property (@(posedge clk) disable iff (rst)
        flush_req |=> (valid_vec == '0));

    // R7: base write in flush mode empties the array
    p_ptb_flush_r7: assert property (@(posedge clk) disable iff (rst)
        (ptb_we && flush_mode) |=> (valid_vec == '0));

    // R7: base write in keep mode leaves valid bits alone
    p_ptb_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (ptb_we && !flush_mode && !flush_req && !fill_en) |=> $stable(valid_vec));

    // R8: never more than one entry answers a lookup
    p_single_match_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lkp_hit_vec));

    // R11: frame output is zero whenever the lookup misses
    p_miss_zero_r11: assert property (@(posedge clk) disable iff (rst)
        !lkp_hit |-> (lkp_pfn == '0));

endmodule

bind tlb_asid_cache tlb_asid_checker #(
    .ENTRIES (ENTRIES),
    .PFN_W   (PFN_W),
    .ASID_W  (ASID_W),
    .PTB_W   (PTB_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .valid_vec   (valid_vec),
    .lkp_hit_vec (lkp_hit_vec),
    .lkp_hit     (lkp_hit),
    .lkp_pfn     (lkp_pfn),
    .asid_we     (asid_we),
    .asid_wdata  (asid_wdata),
    .cur_asid    (cur_asid),
    .ptb_we      (ptb_we),
    .ptb_q       (ptb_q),
    .flush_mode  (flush_mode),
    .flush_req   (flush_req),
    .fill_en     (fill_en)
);

// File: tb/tlb_asid_cache_tb.sv
module tlb_asid_cache_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES    = 16;
    localparam int VPN_W      = 20;
    localparam int PFN_W      = 20;
    localparam int ASID_W     = 8;
    localparam int PTB_W      = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [VPN_W-1:0]  lkp_vpn = '0;
    logic              lkp_hit;
    logic [PFN_W-1:0]  lkp_pfn;
    logic              fill_en = 1'b0;
    logic [VPN_W-1:0]  fill_vpn = '0;
    logic [PFN_W-1:0]  fill_pfn = '0;
    logic              asid_we = 1'b0;
    logic [ASID_W-1:0] asid_wdata = '0;
    logic [ASID_W-1:0] cur_asid;
    logic              ptb_we = 1'b0;
    logic [PTB_W-1:0]  ptb_wdata = '0;
    logic [PTB_W-1:0]  ptb_q;
    logic              flush_mode = 1'b0;
    logic              flush_req = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_asid_cache #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W),
        .ASID_W(ASID_W), .PTB_W(PTB_W)
    ) u_dut (
        .clk(clk), .rst(rst),
        .lkp_vpn(lkp_vpn), .lkp_hit(lkp_hit), .lkp_pfn(lkp_pfn),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .asid_we(asid_we), .asid_wdata(asid_wdata), .cur_asid(cur_asid),
        .ptb_we(ptb_we), .ptb_wdata(ptb_wdata), .ptb_q(ptb_q),
        .flush_mode(flush_mode), .flush_req(flush_req)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Inputs change on the falling edge; the rising edge in between commits.
    task automatic set_asid(input int a);
        @(negedge clk);
        asid_we = 1'b1; asid_wdata = ASID_W'(a);
        @(negedge clk);
        asid_we = 1'b0;
    endtask

    task automatic fill(input int vpn, input int pfn);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = VPN_W'(vpn); fill_pfn = PFN_W'(pfn);
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic flush();
        @(negedge clk);
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
    endtask

    // Combinational lookup: sample shortly after driving, before the next edge.
    task automatic look(input string req, input int vpn, input bit exp_hit, input int exp_pfn);
        @(negedge clk);
        lkp_vpn = VPN_W'(vpn);
        #1;
        check(req, lkp_hit, exp_hit);
        check(req, lkp_pfn, exp_hit ? exp_pfn : 0);
    endtask

    task automatic t_reset();
        check("R1", cur_asid, 0);
        check("R1", ptb_q, 0);
        look("R1", 0, 1'b0, 0);
        look("R11", 5, 1'b0, 0);
    endtask

    task automatic t_tags();
        set_asid(1);
        check("R3", cur_asid, 1);
        fill(10, 100);
        look("R2", 10, 1'b1, 100);
        look("R2", 11, 1'b0, 0);
        set_asid(2);
        look("R3", 10, 1'b0, 0);
        fill(10, 170);
        look("R4", 10, 1'b1, 170);
        set_asid(1);
        look("R4", 10, 1'b1, 100);
    endtask

    task automatic t_shared();
        flush();
        set_asid(1);
        fill(10, 101);
        set_asid(2);
        fill(50, 101);
        look("R5", 50, 1'b1, 101);
        look("R5", 10, 1'b0, 0);
        set_asid(1);
        look("R5", 10, 1'b1, 101);
        look("R5", 50, 1'b0, 0);
    endtask

    task automatic t_flush();
        set_asid(1);
        fill(33, 333);
        look("R6", 33, 1'b1, 333);
        flush();
        look("R6", 33, 1'b0, 0);
        look("R6", 10, 1'b0, 0);
    endtask

    task automatic t_ptb();
        set_asid(5);
        fill(44, 444);
        @(negedge clk);
        flush_mode = 1'b0; ptb_we = 1'b1; ptb_wdata = 32'h0000_1234;
        @(negedge clk);
        ptb_we = 1'b0;
        check("R7", ptb_q, 32'h0000_1234);
        look("R7", 44, 1'b1, 444);
        @(negedge clk);
        flush_mode = 1'b1; ptb_we = 1'b1; ptb_wdata = 32'h0000_5678;
        @(negedge clk);
        ptb_we = 1'b0; flush_mode = 1'b0;
        check("R7", ptb_q, 32'h0000_5678);
        look("R7", 44, 1'b0, 0);
    endtask

    task automatic t_overwrite();
        flush();
        set_asid(3);
        fill(7, 1);
        fill(7, 2);
        look("R8", 7, 1'b1, 2);
        for (int i = 0; i < ENTRIES - 1; i++) fill(100 + i, 1000 + i);
        look("R8", 7, 1'b1, 2);
        for (int i = 0; i < ENTRIES - 1; i++) look("R8", 100 + i, 1'b1, 1000 + i);
    endtask

    task automatic t_round_robin();
        flush();
        set_asid(4);
        for (int i = 0; i < ENTRIES; i++) fill(200 + i, 2000 + i);
        for (int i = 0; i < ENTRIES; i++) look("R9", 200 + i, 1'b1, 2000 + i);
        fill(300, 3000);
        look("R9", 300, 1'b1, 3000);
        look("R9", 200, 1'b0, 0);
        look("R9", 201, 1'b1, 2001);
        fill(301, 3001);
        look("R9", 201, 1'b0, 0);
        look("R9", 202, 1'b1, 2002);
        look("R9", 215, 1'b1, 2015);
    endtask

    task automatic t_collide();
        flush();
        set_asid(6);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = 20; fill_pfn = 222; flush_req = 1'b1;
        @(negedge clk);
        fill_en = 1'b0; flush_req = 1'b0;
        look("R10", 20, 1'b0, 0);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = 21; fill_pfn = 223;
        ptb_we = 1'b1; ptb_wdata = 32'h9; flush_mode = 1'b1;
        @(negedge clk);
        fill_en = 1'b0; ptb_we = 1'b0; flush_mode = 1'b0;
        look("R10", 21, 1'b0, 0);
        fill(22, 224);
        look("R10", 22, 1'b1, 224);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_tags();
        t_shared();
        t_flush();
        t_ptb();
        t_overwrite();
        t_round_robin();
        t_collide();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule